// File: doc/BRIEF.md
# Queue Status Flags and Interrupt Controller

This block keeps the fill-state flags for 64 hardware queues and turns them into per-queue interrupt bits and one combined interrupt line. The queue storage logic reports each change of a queue's fill level on an update port. The report carries the queue number, the new entry count, the nearly-empty level, the nearly-full level and the capacity. The block works out the flags and holds them in status registers that software can read.

The queues form two classes. The 32 lower queues each keep four flags: empty, nearly empty, nearly full and full. They also keep sticky underflow and overflow bits. For its interrupt, each lower queue selects one of eight conditions: one of the four flags, or the inverse of one of them. The 32 upper queues keep only a nearly-empty bit and a full bit, and their interrupt condition is the nearly-empty bit. Interrupt bits are gated by per-queue enables and cleared by writing ones. A small word-wide register port gives software access to everything.

Top module: `qstat_irq`

## Requirements
- R1: Address 0 to 3 hold the lower-queue flags. Queue q sits in word q/8 at bits (q mod 8)*4. Within that field, bit 0 is empty (count 0) and bit 1 is nearly empty (count <= NE level). Bit 2 is nearly full (count + NF level >= capacity) and bit 3 is full (count >= capacity). A flag word changes one cycle after an update for that queue.
- R2: After reset, the following values hold:
  - lower flag words: 0x33333333
  - upper nearly-empty word: all ones
  - upper full word: zero
  - source selects, enables and underflow/overflow words: zero
  - both interrupt words: all ones
  - `irq` and `ctl_bit`: 0
- R3: Upper queue q (32 to 63) uses bit q-32 of address 6 (nearly empty) and of address 7 (full), with the same thresholds as R1.
- R4: Addresses 8 to 11 hold a 4-bit select field per lower queue, at word q/8 and bits (q mod 8)*4. Its low 3 bits pick the condition: 0 empty, 1 nearly empty, 2 nearly full, 3 full, and 4 to 7 the inverse of 0 to 3. A lower interrupt bit sets on the edge after its condition is true while enabled.
- R5: Address 12 enables the lower queues and address 13 the upper queues, at bit q mod 32. An interrupt bit never rises unless its enable was 1 on the previous cycle.
- R6: Address 14 (lower) and address 15 (upper) hold the interrupt bits. Writing 1 to a bit clears it. A set condition in the same cycle wins over the clear.
- R7: `irq` is 1 exactly when some interrupt bit is 1 and its enable is 1.
- R8: Bit 3 of select word 0 drives `ctl_bit`. It has no effect on the condition chosen for queue 0.
- R9: Addresses 4 and 5 hold sticky underflow and overflow bits for the lower queues. Queue q sits in word q/16: bit (q mod 16)*2 is underflow and the next bit is overflow. An update that reports the event sets the bit, writing 1 clears it, and a set wins over a clear.
- R10: Writes to addresses 0, 1, 2, 3, 6 and 7 are ignored.
- R11: An upper interrupt bit sets when the queue's nearly-empty bit and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Fill-level report valid |
| upd_qid | input | 6 | Queue number of the report |
| upd_cnt | input | CW | Entry count after the change |
| upd_ne_lvl | input | CW | Nearly-empty level of the queue |
| upd_nf_lvl | input | CW | Nearly-full distance from capacity |
| upd_cap | input | CW | Queue capacity in entries |
| upd_uflow | input | 1 | Report carries an underflow event |
| upd_oflow | input | 1 | Report carries an overflow event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Combined interrupt |
| ctl_bit | output | 1 | Control bit from select word 0 |

## Verification
Some rules are checked by the assertions on every cycle:
- an interrupt bit rises only when its enable was set;
- interrupt bits and underflow/overflow bits fall only after a write to their word;
- the flag words change only after an update;
- empty implies nearly empty and full implies nearly full;
- the combined line needs some enable.

Other behaviour only the bench scenarios can show:
- the exact flag thresholds;
- each of the eight source selections;
- a set winning over a same-cycle clear;
- the reset map;
- the control bit's independence from queue 0's selection.

// File: rtl/qstat_pkg.sv
`timescale 1ns/1ps
package qstat_pkg;
  localparam int CMAX = 16;
  localparam int FLG_E  = 0;
  localparam int FLG_NE = 1;
  localparam int FLG_NF = 2;
  localparam int FLG_F  = 3;

  typedef enum logic [2:0] {
    SRC_EMPTY, SRC_NEMPTY, SRC_NFULL, SRC_FULL,
    SRC_NOT_EMPTY, SRC_NOT_NEMPTY, SRC_NOT_NFULL, SRC_NOT_FULL
  } src_sel_e;

  typedef enum logic [3:0] {
    A_LO0 = 4'd0, A_LO1 = 4'd1, A_LO2 = 4'd2, A_LO3 = 4'd3,
    A_UO0 = 4'd4, A_UO1 = 4'd5, A_HNE = 4'd6, A_HF = 4'd7,
    A_SEL0 = 4'd8, A_SEL1 = 4'd9, A_SEL2 = 4'd10, A_SEL3 = 4'd11,
    A_ENLO = 4'd12, A_ENHI = 4'd13, A_INTLO = 4'd14, A_INTHI = 4'd15
  } reg_addr_e;

  function automatic logic [3:0] level_flags(input logic [CMAX-1:0] cnt,
                                             input logic [CMAX-1:0] ne,
                                             input logic [CMAX-1:0] nf,
                                             input logic [CMAX-1:0] cap);
    logic [CMAX:0] head;
    logic [3:0] f;
    head      = {1'b0, cnt} + {1'b0, nf};
    f[FLG_E]  = (cnt == '0);
    f[FLG_NE] = (cnt <= ne);
    f[FLG_NF] = (head >= {1'b0, cap});
    f[FLG_F]  = (cnt >= cap);
    return f;
  endfunction

  function automatic logic src_pick(input logic [3:0] flags, input logic [2:0] sel);
    logic hit;
    hit = flags[sel[1:0]];
    return sel[2] ? ~hit : hit;
  endfunction
endpackage

// File: rtl/qstat_level_eval.sv
`timescale 1ns/1ps
module qstat_level_eval #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] ne_lvl,
  input  logic [CW-1:0] nf_lvl,
  input  logic [CW-1:0] cap,
  output logic [3:0]    flags
);
  localparam int W = qstat_pkg::CMAX;

  always_comb begin
    flags = qstat_pkg::level_flags(W'(cnt), W'(ne_lvl), W'(nf_lvl), W'(cap));
  end
endmodule

// File: rtl/qstat_store.sv
`timescale 1ns/1ps
module qstat_store #(
  parameter int NLO = 32,
  parameter int NHI = 32,
  parameter int QW  = 6,
  parameter int DW  = 32,
  parameter int NUW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [QW-1:0]     upd_qid,
  input  logic [3:0]        upd_flags,
  input  logic              upd_uflow,
  input  logic              upd_oflow,
  input  logic [NUW-1:0]    uo_wr,
  input  logic [DW-1:0]     wdata,
  output logic [NLO*4-1:0]  lo_stat,
  output logic [NHI-1:0]    hi_ne,
  output logic [NHI-1:0]    hi_f,
  output logic [NLO*2-1:0]  uo_stat,
  output logic              upd_lo_hit,
  output logic              upd_hi_hit
);
  localparam int QPW_UO = DW / 2;

  logic [QW-1:0] hi_idx;

  assign upd_lo_hit = upd_en && (upd_qid < QW'(NLO));
  assign upd_hi_hit = upd_en && !(upd_qid < QW'(NLO));
  assign hi_idx     = upd_qid - QW'(NLO);

  for (genvar q = 0; q < NLO; q++) begin : g_lo
    logic [3:0] nib_r;
    logic [1:0] uo_r;
    logic [1:0] uo_clr;
    logic [1:0] uo_set;
    logic       hit;

    assign hit    = upd_lo_hit && (upd_qid == QW'(q));
    assign uo_clr = uo_wr[q / QPW_UO] ? wdata[(q % QPW_UO)*2 +: 2] : 2'b00;
    assign uo_set = hit ? {upd_oflow, upd_uflow} : 2'b00;

    always_ff @(posedge clk) begin
      if (rst) begin
        nib_r <= 4'b0011;
        uo_r  <= 2'b00;
      end else begin
        if (hit) nib_r <= upd_flags;
        uo_r <= (uo_r & ~uo_clr) | uo_set;
      end
    end

    assign lo_stat[q*4 +: 4] = nib_r;
    assign uo_stat[q*2 +: 2] = uo_r;
  end

  for (genvar h = 0; h < NHI; h++) begin : g_hi
    logic ne_r;
    logic f_r;
    logic hit;

    assign hit = upd_hi_hit && (hi_idx == QW'(h));

    always_ff @(posedge clk) begin
      if (rst) begin
        ne_r <= 1'b1;
        f_r  <= 1'b0;
      end else if (hit) begin
        ne_r <= upd_flags[qstat_pkg::FLG_NE];
        f_r  <= upd_flags[qstat_pkg::FLG_F];
      end
    end

    assign hi_ne[h] = ne_r;
    assign hi_f[h]  = f_r;
  end
endmodule

// File: rtl/qstat_irq_gen.sv
`timescale 1ns/1ps
module qstat_irq_gen #(
  parameter int NLO = 32,
  parameter int NHI = 32,
  parameter int DW  = 32,
  parameter int NSW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLO*4-1:0]  lo_stat,
  input  logic [NHI-1:0]    hi_ne,
  input  logic [NSW-1:0]    sel_wr,
  input  logic [1:0]        en_wr,
  input  logic [1:0]        int_wr,
  input  logic [DW-1:0]     wdata,
  output logic [NSW*DW-1:0] sel_flat,
  output logic [NLO-1:0]    en_lo,
  output logic [NHI-1:0]    en_hi,
  output logic [NLO-1:0]    int_lo,
  output logic [NHI-1:0]    int_hi,
  output logic [NLO-1:0]    set_lo,
  output logic [NHI-1:0]    set_hi,
  output logic              irq,
  output logic              ctl_bit
);
  for (genvar w = 0; w < NSW; w++) begin : g_sel
    logic [DW-1:0] word_r;
    always_ff @(posedge clk) begin
      if (rst)            word_r <= '0;
      else if (sel_wr[w]) word_r <= wdata;
    end
    assign sel_flat[w*DW +: DW] = word_r;
  end

  for (genvar q = 0; q < NLO; q++) begin : g_cond
    assign set_lo[q] = qstat_pkg::src_pick(lo_stat[q*4 +: 4], sel_flat[q*4 +: 3]) & en_lo[q];
  end

  assign set_hi = hi_ne & en_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_lo  <= '0;
      en_hi  <= '0;
      int_lo <= '1;
      int_hi <= '1;
    end else begin
      if (en_wr[0]) en_lo <= wdata[NLO-1:0];
      if (en_wr[1]) en_hi <= wdata[NHI-1:0];
      int_lo <= (int_lo & ~(int_wr[0] ? wdata[NLO-1:0] : '0)) | set_lo;
      int_hi <= (int_hi & ~(int_wr[1] ? wdata[NHI-1:0] : '0)) | set_hi;
    end
  end

  assign irq     = (|(int_lo & en_lo)) | (|(int_hi & en_hi));
  assign ctl_bit = sel_flat[3];
endmodule

// File: rtl/qstat_irq.sv
`timescale 1ns/1ps
module qstat_irq #(
  parameter int NQ_LO = 32,
  parameter int NQ_HI = 32,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic [5:0]    upd_qid,
  input  logic [CW-1:0] upd_cnt,
  input  logic [CW-1:0] upd_ne_lvl,
  input  logic [CW-1:0] upd_nf_lvl,
  input  logic [CW-1:0] upd_cap,
  input  logic          upd_uflow,
  input  logic          upd_oflow,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          ctl_bit
);
  import qstat_pkg::*;

  localparam int DW  = 32;
  localparam int QW  = 6;
  localparam int NSW = (NQ_LO * 4) / DW;
  localparam int NUW = (NQ_LO * 2) / DW;

  logic [3:0]         upd_flags;
  logic [NQ_LO*4-1:0] lo_stat;
  logic [NQ_HI-1:0]   hi_ne;
  logic [NQ_HI-1:0]   hi_f;
  logic [NQ_LO*2-1:0] uo_stat;
  logic               upd_lo_hit;
  logic               upd_hi_hit;
  logic [NSW*DW-1:0]  sel_flat;
  logic [NQ_LO-1:0]   en_lo;
  logic [NQ_HI-1:0]   en_hi;
  logic [NQ_LO-1:0]   int_lo;
  logic [NQ_HI-1:0]   int_hi;
  logic [NQ_LO-1:0]   set_lo;
  logic [NQ_HI-1:0]   set_hi;
  logic [NSW-1:0]     sel_wr;
  logic [NUW-1:0]     uo_wr;
  logic [1:0]         en_wr;
  logic [1:0]         int_wr;

  always_comb begin
    for (int w = 0; w < NSW; w++) sel_wr[w] = reg_we && (reg_addr == 4'(A_SEL0) + 4'(w));
    for (int w = 0; w < NUW; w++) uo_wr[w]  = reg_we && (reg_addr == 4'(A_UO0) + 4'(w));
    en_wr  = {reg_we && (reg_addr == A_ENHI),  reg_we && (reg_addr == A_ENLO)};
    int_wr = {reg_we && (reg_addr == A_INTHI), reg_we && (reg_addr == A_INTLO)};
  end

  qstat_level_eval #(.CW(CW)) u_eval (
    .cnt    (upd_cnt),
    .ne_lvl (upd_ne_lvl),
    .nf_lvl (upd_nf_lvl),
    .cap    (upd_cap),
    .flags  (upd_flags)
  );

  qstat_store #(.NLO(NQ_LO), .NHI(NQ_HI), .QW(QW), .DW(DW), .NUW(NUW)) u_store (
    .clk        (clk),
    .rst        (rst),
    .upd_en     (upd_en),
    .upd_qid    (upd_qid),
    .upd_flags  (upd_flags),
    .upd_uflow  (upd_uflow),
    .upd_oflow  (upd_oflow),
    .uo_wr      (uo_wr),
    .wdata      (reg_wdata),
    .lo_stat    (lo_stat),
    .hi_ne      (hi_ne),
    .hi_f       (hi_f),
    .uo_stat    (uo_stat),
    .upd_lo_hit (upd_lo_hit),
    .upd_hi_hit (upd_hi_hit)
  );

  qstat_irq_gen #(.NLO(NQ_LO), .NHI(NQ_HI), .DW(DW), .NSW(NSW)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .lo_stat  (lo_stat),
    .hi_ne    (hi_ne),
    .sel_wr   (sel_wr),
    .en_wr    (en_wr),
    .int_wr   (int_wr),
    .wdata    (reg_wdata),
    .sel_flat (sel_flat),
    .en_lo    (en_lo),
    .en_hi    (en_hi),
    .int_lo   (int_lo),
    .int_hi   (int_hi),
    .set_lo   (set_lo),
    .set_hi   (set_hi),
    .irq      (irq),
    .ctl_bit  (ctl_bit)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LO0, A_LO1, A_LO2, A_LO3: reg_rdata = lo_stat[reg_addr[1:0]*DW +: DW];
      A_UO0, A_UO1:               reg_rdata = uo_stat[reg_addr[0]*DW +: DW];
      A_HNE:                      reg_rdata = DW'(hi_ne);
      A_HF:                       reg_rdata = DW'(hi_f);
      A_SEL0, A_SEL1, A_SEL2, A_SEL3: reg_rdata = sel_flat[reg_addr[1:0]*DW +: DW];
      A_ENLO:                     reg_rdata = DW'(en_lo);
      A_ENHI:                     reg_rdata = DW'(en_hi);
      A_INTLO:                    reg_rdata = DW'(int_lo);
      default:                    reg_rdata = DW'(int_hi);
    endcase
  end
endmodule

// File: rtl/qstat_irq_chk.sv
`timescale 1ns/1ps
module qstat_irq_chk #(
  parameter int NLO = 32,
  parameter int NHI = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             upd_en,
  input logic [NLO*4-1:0] lo_stat,
  input logic [NHI-1:0]   hi_ne,
  input logic [NHI-1:0]   hi_f,
  input logic [NLO*2-1:0] uo_stat,
  input logic [1:0]       uo_wr,
  input logic [NLO-1:0]   en_lo,
  input logic [NHI-1:0]   en_hi,
  input logic [NLO-1:0]   int_lo,
  input logic [NHI-1:0]   int_hi,
  input logic [1:0]       int_wr,
  input logic             irq
);
  function automatic logic flags_consistent(input logic [NLO*4-1:0] s);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NLO; i++) begin
      if (s[i*4] && !s[i*4+1])   ok = 1'b0;
      if (s[i*4+3] && !s[i*4+2]) ok = 1'b0;
    end
    return ok;
  endfunction

  // R5
  lo_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((int_lo & ~$past(int_lo)) & ~$past(en_lo)) == '0);

  // R11
  hi_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((int_hi & ~$past(int_hi)) & ~$past(en_hi)) == '0);

  // R6
  int_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (|(($past(int_lo) & ~int_lo)) || |(($past(int_hi) & ~int_hi))) |-> (|$past(int_wr)));

  // R9
  uo_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(uo_stat) & ~uo_stat)) |-> (|$past(uo_wr)));

  // R1
  flag_order_chk: assert property (@(posedge clk) disable iff (rst)
    flags_consistent(lo_stat));

  // R10
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(upd_en) |-> ($stable(lo_stat) && $stable(hi_ne) && $stable(hi_f)));

  // R7
  irq_need_en_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((|en_lo) || (|en_hi)));
endmodule

bind qstat_irq qstat_irq_chk #(.NLO(NQ_LO), .NHI(NQ_HI)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .upd_en  (upd_en),
  .lo_stat (lo_stat),
  .hi_ne   (hi_ne),
  .hi_f    (hi_f),
  .uo_stat (uo_stat),
  .uo_wr   (uo_wr),
  .en_lo   (en_lo),
  .en_hi   (en_hi),
  .int_lo  (int_lo),
  .int_hi  (int_hi),
  .int_wr  (int_wr),
  .irq     (irq)
);

// File: tb/test_qstat_irq.sv
`timescale 1ns/1ps
module test_qstat_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        upd_en;
  logic [5:0]  upd_qid;
  logic [7:0]  upd_cnt, upd_ne_lvl, upd_nf_lvl, upd_cap;
  logic        upd_uflow, upd_oflow;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq, ctl_bit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [3:0]  m_lo [32];
  logic [1:0]  m_uo [32];
  logic [31:0] m_sel [4];
  logic [31:0] m_hne, m_hf, m_en_lo, m_en_hi, m_int_lo, m_int_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  qstat_irq i_qstat_irq (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_qid(upd_qid), .upd_cnt(upd_cnt),
    .upd_ne_lvl(upd_ne_lvl), .upd_nf_lvl(upd_nf_lvl), .upd_cap(upd_cap),
    .upd_uflow(upd_uflow), .upd_oflow(upd_oflow), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .ctl_bit(ctl_bit)
  );

  function automatic logic [3:0] flags_of(int cnt, int ne, int nf, int cap);
    logic [3:0] f;
    f[0] = (cnt == 0);
    f[1] = !(cnt > ne);
    f[2] = ((cap - cnt) <= nf);
    f[3] = !(cnt < cap);
    return f;
  endfunction

  function automatic logic pick(logic [3:0] f, logic [2:0] s);
    logic v;
    v = f[s % 4];
    return (s >= 4) ? !v : v;
  endfunction

  function automatic logic [31:0] exp_reg(int a);
    logic [31:0] v;
    v = '0;
    if (a < 4)       for (int i = 0; i < 8; i++)  v[i*4 +: 4] = m_lo[a*8 + i];
    else if (a < 6)  for (int i = 0; i < 16; i++) v[i*2 +: 2] = m_uo[(a-4)*16 + i];
    else if (a == 6) v = m_hne;
    else if (a == 7) v = m_hf;
    else if (a < 12) v = m_sel[a-8];
    else if (a == 12) v = m_en_lo;
    else if (a == 13) v = m_en_hi;
    else if (a == 14) v = m_int_lo;
    else v = m_int_hi;
    return v;
  endfunction

  function automatic string req_of(int a);
    if (a < 4)  return "R1";
    if (a < 6)  return "R9";
    if (a < 8)  return "R3";
    if (a < 12) return "R4";
    if (a < 14) return "R5";
    return "R6";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_reg(int a, output logic [31:0] d);
    reg_addr = 4'(a);
    #0.2;
    d = reg_rdata;
  endtask

  task automatic check_all();
    logic [31:0] d;
    for (int a = 0; a < 16; a++) begin
      read_reg(a, d);
      chk(req_of(a), d, exp_reg(a));
    end
    chk("R7", 32'(irq), 32'((|(m_int_lo & m_en_lo)) | (|(m_int_hi & m_en_hi))));
    chk("R8", 32'(ctl_bit), 32'(m_sel[0][3]));
  endtask

  task automatic step();
    logic [31:0] set_lo, set_hi, clr_lo, clr_hi, n_en_lo, n_en_hi;
    logic [3:0]  nf, n_lo [32];
    logic [1:0]  n_uo [32];
    logic [31:0] n_sel [4];
    logic [31:0] n_hne, n_hf;
    for (int q = 0; q < 32; q++)
      set_lo[q] = pick(m_lo[q], m_sel[q/8][(q%8)*4 +: 3]) & m_en_lo[q];
    set_hi = m_hne & m_en_hi;
    clr_lo = (reg_we && reg_addr == 14) ? reg_wdata : '0;
    clr_hi = (reg_we && reg_addr == 15) ? reg_wdata : '0;
    nf = flags_of(int'(upd_cnt), int'(upd_ne_lvl), int'(upd_nf_lvl), int'(upd_cap));
    n_hne = m_hne; n_hf = m_hf;
    for (int q = 0; q < 32; q++) begin
      logic [1:0] c, s;
      n_lo[q] = (upd_en && upd_qid == 6'(q)) ? nf : m_lo[q];
      c = (reg_we && reg_addr == 4'(4 + q/16)) ? reg_wdata[(q%16)*2 +: 2] : 2'b00;
      s = (upd_en && upd_qid == 6'(q)) ? {upd_oflow, upd_uflow} : 2'b00;
      n_uo[q] = (m_uo[q] & ~c) | s;
    end
    if (upd_en && upd_qid >= 32) begin
      n_hne[upd_qid - 32] = nf[1];
      n_hf[upd_qid - 32]  = nf[3];
    end
    for (int w = 0; w < 4; w++)
      n_sel[w] = (reg_we && reg_addr == 4'(8 + w)) ? reg_wdata : m_sel[w];
    n_en_lo = (reg_we && reg_addr == 12) ? reg_wdata : m_en_lo;
    n_en_hi = (reg_we && reg_addr == 13) ? reg_wdata : m_en_hi;
    @(posedge clk);
    #1;
    m_int_lo = (m_int_lo & ~clr_lo) | set_lo;
    m_int_hi = (m_int_hi & ~clr_hi) | set_hi;
    for (int q = 0; q < 32; q++) begin m_lo[q] = n_lo[q]; m_uo[q] = n_uo[q]; end
    for (int w = 0; w < 4; w++) m_sel[w] = n_sel[w];
    m_hne = n_hne; m_hf = n_hf; m_en_lo = n_en_lo; m_en_hi = n_en_hi;
    upd_en = 0; reg_we = 0; upd_uflow = 0; upd_oflow = 0;
  endtask

  task automatic set_upd(int q, int cnt, int ne, int nf, int cap, bit uf, bit of);
    upd_en = 1; upd_qid = 6'(q); upd_cnt = 8'(cnt); upd_ne_lvl = 8'(ne);
    upd_nf_lvl = 8'(nf); upd_cap = 8'(cap); upd_uflow = uf; upd_oflow = of;
  endtask

  task automatic set_wr(int a, logic [31:0] d);
    reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
  endtask

  task automatic do_upd(int q, int cnt, int ne, int nf, int cap, bit uf, bit of);
    set_upd(q, cnt, ne, nf, cap, uf, of); step(); check_all();
  endtask

  task automatic do_wr(int a, logic [31:0] d);
    set_wr(a, d); step(); check_all();
  endtask

  initial begin
    logic [31:0] d;
    int unsigned r;
    rst = 1; upd_en = 0; upd_qid = 0; upd_cnt = 0; upd_ne_lvl = 0; upd_nf_lvl = 0;
    upd_cap = 0; upd_uflow = 0; upd_oflow = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    for (int q = 0; q < 32; q++) begin m_lo[q] = 4'h3; m_uo[q] = 2'b00; end
    for (int w = 0; w < 4; w++) m_sel[w] = '0;
    m_hne = '1; m_hf = '0; m_en_lo = '0; m_en_hi = '0; m_int_lo = '1; m_int_hi = '1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R2: reset map
    read_reg(0, d); chk("R2", d, 32'h33333333);
    read_reg(6, d); chk("R2", d, 32'hFFFFFFFF);
    read_reg(7, d); chk("R2", d, 32'h0);
    read_reg(14, d); chk("R2", d, 32'hFFFFFFFF);
    chk("R2", 32'(irq), 0);
    check_all();

    // R10: status words ignore writes
    do_wr(0, 32'hFFFFFFFF); read_reg(0, d); chk("R10", d, 32'h33333333);
    do_wr(6, 32'h0);        read_reg(6, d); chk("R10", d, 32'hFFFFFFFF);
    do_wr(7, 32'hFFFFFFFF); read_reg(7, d); chk("R10", d, 32'h0);

    // R1: thresholds on queue 9 (word 1, bits 7:4)
    do_upd(9, 10, 2, 2, 10, 0, 0); read_reg(1, d); chk("R1", 32'(d[7:4]), 32'hC);
    do_upd(9, 2, 2, 2, 10, 0, 0);  read_reg(1, d); chk("R1", 32'(d[7:4]), 32'h2);
    do_upd(9, 0, 2, 2, 10, 0, 0);  read_reg(1, d); chk("R1", 32'(d[7:4]), 32'h3);
    // R3: upper queue 40 full
    do_upd(40, 8, 1, 0, 8, 0, 0);  read_reg(7, d); chk("R3", 32'(d[8]), 1);
    read_reg(6, d); chk("R3", 32'(d[8]), 0);

    // R8: control bit independent of queue 0 select
    do_wr(8, 32'h8); chk("R8", 32'(ctl_bit), 1);
    do_wr(12, 32'h1); chk("R7", 32'(irq), 1);
    // R6: set wins over clear while empty is still selected and true
    do_wr(14, 32'h1); read_reg(14, d); chk("R6", 32'(d[0]), 1);
    do_upd(0, 5, 2, 2, 10, 0, 0);
    do_wr(14, 32'h1); read_reg(14, d); chk("R6", 32'(d[0]), 0);
    chk("R7", 32'(irq), 0);
    // R4: inverse-of-empty selection sets the bit
    do_wr(8, 32'h4); chk("R8", 32'(ctl_bit), 0);
    step(); check_all(); read_reg(14, d); chk("R4", 32'(d[0]), 1);
    // R11: upper queue condition is nearly empty
    do_wr(13, 32'h1);
    do_upd(32, 9, 2, 2, 10, 0, 0);
    do_wr(15, 32'h1); read_reg(15, d); chk("R11", 32'(d[0]), 0);
    // R5: disabled bits stay clear
    do_wr(12, 32'h0); do_wr(14, 32'hFFFFFFFF);
    step(); check_all(); read_reg(14, d); chk("R5", d, 32'h0);
    // R9: sticky underflow and clear
    do_upd(3, 0, 1, 1, 4, 1, 0); read_reg(4, d); chk("R9", 32'(d[7:6]), 32'h1);
    step(); check_all(); read_reg(4, d); chk("R9", 32'(d[7:6]), 32'h1);
    do_wr(4, 32'h40); read_reg(4, d); chk("R9", 32'(d[7:6]), 32'h0);

    // random mix
    r = $urandom(32'd2024);
    for (int it = 0; it < 600; it++) begin
      int cap, cnt;
      cap = 1 + int'($urandom % 200);
      case ($urandom % 4)
        0: cnt = 0;
        1: cnt = cap;
        default: cnt = int'($urandom % (cap + 1));
      endcase
      if ($urandom % 3 != 0)
        set_upd(int'($urandom % 64), cnt, int'($urandom % (cap + 1)),
                int'($urandom % (cap + 1)), cap, 1'($urandom), 1'($urandom));
      if ($urandom % 2 == 0)
        set_wr(int'($urandom % 16), $urandom);
      step();
      check_all();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule